// File: doc/BRIEF.md
# Shift-and-Add Decaying Exponential Unit

This block evaluates exp(-a) for a non-negative fixed-point argument `a` and is meant to sit after the squared-distance stage of a Gaussian kernel evaluator. The squared distance, already scaled by the kernel width, enters as `a`, and the kernel value leaves as the result. It uses only adders, subtractors, shifters and comparators against constants. It has no multiplier and no function lookup memory.

Each argument is first reduced by a bank of comparators against multiples of ln2, so that a = q·ln2 + r with 0 ≤ r < ln2. The remainder r then runs through an iterative hyperbolic rotation engine. That engine starts from the reciprocal of its gain and repeats the shift indices 4 and 13. The reduction lifts the usual argument limit of about 1.1 for this kind of rotation. The sum of the two rotated coordinates equals exp(-r), and a right shift by q applies the 2^-q factor. One argument is handled at a time. A start strobe begins the work, `busy_o` covers it, and a one-cycle done strobe presents the result.

The default configuration has 12 result fraction bits, a 4-bit integer argument part and 6 guard bits. It runs 16 micro-rotations: shift indices 1 to 14, with 4 and 13 done twice. Widening `FRAC_W` to 14 gives the higher-precision configuration, and all tables and counts follow from that parameter.

Top module: `exp_cordic_unit`

## Requirements
- R1: During and right after reset, `busy_o` is 0, `done_o` is 0 and `res_o` is 0.
- R2: A start is accepted when `start_i` is 1 while `busy_o` is 0. From the next cycle `busy_o` is 1 for 17 cycles, which are 16 rotations plus one output cycle. `done_o` is 1 for exactly one cycle, starting at the 17th rising edge after the accepting edge, and `busy_o` falls in that same cycle.
- R3: A `start_i` pulse while `busy_o` is 1 is ignored. It does not change the result, the timing, or the number of done pulses.
- R4: `arg_i` is unsigned with 12 fraction bits, so a = arg_i/4096. `res_o` is unsigned with 12 fraction bits. For 0 ≤ a < ln2, `res_o` is within 2 LSB of round(4096·exp(-a)).
- R5: For ln2 ≤ a < 13·ln2, which lies beyond the direct rotation range, `res_o` is within 2 LSB of round(4096·exp(-a)).
- R6: `res_o` never exceeds 4096, which is 1.0. For a = 0 it is 4095 or 4096.
- R7: When the reduction shift count q = floor(a/ln2) is 13 or more, which is at least the 13-bit output width, `res_o` is exactly 0.
- R8: `res_o` changes only in the cycle in which `done_o` is 1, and it holds its value between done pulses.
- R9: A start presented in the cycle in which `done_o` is 1 is accepted. It produces its result with the same latency as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| start_i | input | 1 | Starts an evaluation when the unit is idle |
| arg_i | input | ARG_IW+FRAC_W (16) | Argument a, unsigned, FRAC_W fraction bits |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | One-cycle strobe: `res_o` holds a new result |
| res_o | output | FRAC_W+1 (13) | exp(-a), unsigned, FRAC_W fraction bits |

## Verification
A wrong arctanh constant, gain constant, rotation direction or reduction multiple does not show up while the rotation is running. It shows at the next done strobe, 17 cycles after acceptance, as a result outside the 2 LSB band for some argument. Remainders near 0 and near ln2 are included because rotation errors grow at those ends. Arguments on both sides of a few ln2 multiples are included because reduction faults only appear there. A control fault, such as a lost repeat step, a wrong counter limit or a start accepted while busy, shows at once as a done strobe that arrives early, late or twice, and as a shifted `busy_o` edge.

// File: rtl/exp_cordic_pkg.sv
package exp_cordic_pkg;

  // fixed-point scale used for elaboration-time constant evaluation
  localparam int unsigned FX_S = 60;

  typedef enum logic [1:0] {ST_IDLE, ST_ITER, ST_FIN} cordic_st_e;

  function automatic logic [63:0] fx_round(input logic [63:0] v, input int unsigned fb);
    return (v + (64'd1 << (FX_S - fb - 1))) >> (FX_S - fb);
  endfunction

  // arctanh(2^-i) by its odd power series, fb fraction bits
  function automatic logic [63:0] atanh_pow2(input int unsigned i, input int unsigned fb);
    logic [63:0] p;
    logic [63:0] acc;
    p   = 64'd1 << (FX_S - i);
    acc = '0;
    for (int k = 0; k < 40; k++) begin
      acc = acc + p / 64'(2 * k + 1);
      p   = p >> (2 * i);
    end
    return fx_round(acc, fb);
  endfunction

  // ln2 = 2*arctanh(1/3), fb fraction bits
  function automatic logic [63:0] ln2_fx(input int unsigned fb);
    logic [63:0] p;
    logic [63:0] acc;
    p   = (64'd1 << FX_S) / 64'd3;
    acc = '0;
    for (int k = 0; k < 40; k++) begin
      acc = acc + p / 64'(2 * k + 1);
      p   = p / 64'd9;
    end
    return fx_round(acc << 1, fb);
  endfunction

  // shift indices 4, 13, 40, ... are executed twice
  function automatic bit is_repeat(input int unsigned i);
    int unsigned k;
    bit r;
    k = 4;
    r = 1'b0;
    for (int j = 0; j < 8; j++) begin
      if (i == k) r = 1'b1;
      k = 3 * k + 1;
    end
    return r;
  endfunction

  function automatic int unsigned n_steps(input int unsigned last_i);
    int unsigned cnt;
    cnt = 0;
    for (int unsigned i = 1; i <= last_i; i++) cnt += is_repeat(i) ? 2 : 1;
    return cnt;
  endfunction

  function automatic int unsigned step_shift(input int unsigned s, input int unsigned last_i);
    int unsigned cnt;
    int unsigned res;
    cnt = 0;
    res = 1;
    for (int unsigned i = 1; i <= last_i; i++) begin
      for (int unsigned rr = 0; rr < (is_repeat(i) ? 2 : 1); rr++) begin
        if (cnt == s) res = i;
        cnt++;
      end
    end
    return res;
  endfunction

  function automatic logic [63:0] isqrt64(input logic [63:0] v);
    logic [63:0] res;
    logic [63:0] t;
    res = '0;
    for (int b = 31; b >= 0; b--) begin
      t = res | (64'd1 << b);
      if (t * t <= v) res = t;
    end
    return res;
  endfunction

  // reciprocal of the hyperbolic gain over the whole step schedule
  function automatic logic [63:0] inv_gain(input int unsigned last_i, input int unsigned fb);
    logic [63:0] prod;
    logic [63:0] s;
    prod = 64'd1 << 40;
    for (int unsigned i = 1; i <= last_i; i++) begin
      for (int unsigned rr = 0; rr < (is_repeat(i) ? 2 : 1); rr++)
        prod = prod - (prod >> (2 * i));
    end
    s = isqrt64(prod << 20);
    return ((64'd1 << (30 + fb)) + (s >> 1)) / s;
  endfunction

  // largest multiple count of ln2 reachable by the argument
  function automatic int unsigned q_max(input int unsigned arg_w, input int unsigned fb_arg,
                                        input int unsigned fb_int);
    logic [63:0] ln;
    logic [63:0] maxv;
    int unsigned cnt;
    ln   = ln2_fx(fb_int);
    maxv = ((64'd1 << arg_w) - 64'd1) << (fb_int - fb_arg);
    cnt  = 1;
    for (int unsigned k = 1; k < 64; k++) if (64'(k) * ln <= maxv) cnt = k;
    return cnt;
  endfunction

endpackage

// File: rtl/exp_cordic_reduce.sv
module exp_cordic_reduce
  import exp_cordic_pkg::*;
#(
  parameter int ARG_W   = 16,
  parameter int GUARD_W = 6,
  parameter int IF      = 18,
  parameter int Q_MAX   = 23,
  parameter int QW      = 5
) (
  input  logic [ARG_W-1:0] arg_i,
  output logic [QW-1:0]    q_o,
  output logic [IF-1:0]    r_o
);

  localparam int AEW = ARG_W + GUARD_W;
  localparam logic [63:0] LN2_I = ln2_fx(IF);

  logic [AEW-1:0] a_ext;
  logic [AEW-1:0] mult_tbl [Q_MAX];
  logic [Q_MAX-1:0] ge;
  logic [AEW-1:0] base;

  assign a_ext = {arg_i, {GUARD_W{1'b0}}};

  // comparator bank against k*ln2, k = 1..Q_MAX (thermometer result)
  for (genvar k = 1; k <= Q_MAX; k++) begin : g_mult
    localparam logic [63:0] MK = 64'(k) * LN2_I;
    assign mult_tbl[k-1] = AEW'(MK);
    assign ge[k-1]       = (a_ext >= mult_tbl[k-1]);
  end

  always_comb begin
    q_o  = '0;
    base = '0;
    for (int k = 1; k <= Q_MAX; k++) begin
      if (ge[k-1]) begin
        q_o  = QW'(k);
        base = mult_tbl[k-1];
      end
    end
    r_o = IF'(a_ext - base);
  end

endmodule

// File: rtl/exp_cordic_angles.sv
module exp_cordic_angles
  import exp_cordic_pkg::*;
#(
  parameter int LAST_I  = 14,
  parameter int N_STEPS = 16,
  parameter int SW      = 4,
  parameter int SHW     = 4,
  parameter int IF      = 18
) (
  input  logic [SW-1:0]  idx_i,
  output logic [SHW-1:0] shift_o,
  output logic [IF-1:0]  angle_o
);

  logic [SHW-1:0] sh_tbl [N_STEPS];
  logic [IF-1:0]  an_tbl [N_STEPS];

  for (genvar s = 0; s < N_STEPS; s++) begin : g_step
    localparam int unsigned SH_S = step_shift(s, LAST_I);
    assign sh_tbl[s] = SHW'(SH_S);
    assign an_tbl[s] = IF'(atanh_pow2(SH_S, IF));
  end

  always_comb begin
    shift_o = '0;
    angle_o = '0;
    for (int s = 0; s < N_STEPS; s++) begin
      if (idx_i == SW'(s)) begin
        shift_o = sh_tbl[s];
        angle_o = an_tbl[s];
      end
    end
  end

endmodule

// File: rtl/exp_cordic_core.sv
module exp_cordic_core #(
  parameter int IW  = 21,
  parameter int IF  = 18,
  parameter int SHW = 4,
  parameter logic [IW-1:0] INV_GAIN = '0
) (
  input  logic                 clk,
  input  logic                 load_i,
  input  logic                 step_i,
  input  logic [IF-1:0]        r_i,
  input  logic [SHW-1:0]       shift_i,
  input  logic [IF-1:0]        angle_i,
  output logic signed [IW-1:0] sum_o
);

  logic signed [IW-1:0] x_q, y_q, z_q;
  logic signed [IW-1:0] x_n, y_n, z_n;
  logic signed [IW-1:0] xs, ys, ang_s;

  always_comb begin
    x_n   = x_q;
    y_n   = y_q;
    z_n   = z_q;
    xs    = x_q >>> shift_i;
    ys    = y_q >>> shift_i;
    ang_s = $signed({{(IW-IF){1'b0}}, angle_i});
    if (load_i) begin
      x_n = $signed(INV_GAIN);
      y_n = '0;
      z_n = -$signed({{(IW-IF){1'b0}}, r_i});
    end else if (step_i) begin
      if (!z_q[IW-1]) begin
        x_n = x_q + ys;
        y_n = y_q + xs;
        z_n = z_q - ang_s;
      end else begin
        x_n = x_q - ys;
        y_n = y_q - xs;
        z_n = z_q + ang_s;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load_i || step_i) begin
      x_q <= x_n;
      y_q <= y_n;
      z_q <= z_n;
    end
  end

  assign sum_o = x_q + y_q;

endmodule

// File: rtl/exp_cordic_ctrl.sv
module exp_cordic_ctrl
  import exp_cordic_pkg::*;
#(
  parameter int N_STEPS = 16,
  parameter int SW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          load_o,
  output logic          step_o,
  output logic          fin_o,
  output logic          busy_o,
  output logic [SW-1:0] idx_o
);

  cordic_st_e    state_q, state_n;
  logic [SW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_n = ST_ITER;
          cnt_n   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_ITER: begin
        cnt_en = 1'b1;
        cnt_n  = cnt_q + SW'(1);
        if (cnt_q == SW'(N_STEPS - 1)) state_n = ST_FIN;
      end
      ST_FIN:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      if (cnt_en) cnt_q <= cnt_n;
    end
  end

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_ITER);
  assign fin_o  = (state_q == ST_FIN);
  assign busy_o = (state_q != ST_IDLE);
  assign idx_o  = cnt_q;

endmodule

// File: rtl/exp_cordic_unit.sv
module exp_cordic_unit
  import exp_cordic_pkg::*;
#(
  parameter int FRAC_W  = 12,
  parameter int ARG_IW  = 4,
  parameter int GUARD_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [ARG_IW+FRAC_W-1:0] arg_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [FRAC_W:0]          res_o
);

  localparam int ARG_W   = ARG_IW + FRAC_W;
  localparam int OUT_W   = FRAC_W + 1;
  localparam int IF      = FRAC_W + GUARD_W;
  localparam int IW      = IF + 3;
  localparam int LAST_I  = FRAC_W + 2;
  localparam int N_STEPS = int'(n_steps(LAST_I));
  localparam int SW      = $clog2(N_STEPS);
  localparam int SHW     = $clog2(LAST_I + 1);
  localparam int Q_MAX   = int'(q_max(ARG_W, FRAC_W, IF));
  localparam int QW      = $clog2(Q_MAX + 1);
  localparam logic [IW-1:0] INV_G = IW'(inv_gain(LAST_I, IF));
  localparam logic [IW:0]   ONE_V = (IW+1)'(1) << FRAC_W;

  logic          load, step, fin;
  logic [SW-1:0] idx;
  logic [QW-1:0] q_red, q_q;
  logic [IF-1:0] r_red;
  logic [SHW-1:0] shift;
  logic [IF-1:0]  angle;
  logic signed [IW-1:0] sum_s;

  logic [IW:0]      sum_u, rnd_v;
  logic [7:0]       tsh;
  logic [OUT_W-1:0] res_n, res_q;
  logic             done_q;

  exp_cordic_ctrl #(.N_STEPS(N_STEPS), .SW(SW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .load_o(load), .step_o(step), .fin_o(fin), .busy_o(busy_o), .idx_o(idx)
  );

  exp_cordic_reduce #(.ARG_W(ARG_W), .GUARD_W(GUARD_W), .IF(IF), .Q_MAX(Q_MAX), .QW(QW)) i_reduce (
    .arg_i(arg_i), .q_o(q_red), .r_o(r_red)
  );

  exp_cordic_angles #(.LAST_I(LAST_I), .N_STEPS(N_STEPS), .SW(SW), .SHW(SHW), .IF(IF)) i_angles (
    .idx_i(idx), .shift_o(shift), .angle_o(angle)
  );

  exp_cordic_core #(.IW(IW), .IF(IF), .SHW(SHW), .INV_GAIN(INV_G)) i_core (
    .clk(clk), .load_i(load), .step_i(step), .r_i(r_red),
    .shift_i(shift), .angle_i(angle), .sum_o(sum_s)
  );

  // shift count is kept for the output stage
  always_ff @(posedge clk) begin
    if (load) q_q <= q_red;
  end

  // 2^-q scaling, guard-bit removal, rounding and saturation
  always_comb begin
    tsh   = 8'(GUARD_W) + 8'(q_q);
    sum_u = {1'b0, sum_s};
    rnd_v = (sum_u + ((IW+1)'(1) << (tsh - 8'd1))) >> tsh;
    if (sum_s[IW-1] || (int'(q_q) >= OUT_W)) res_n = '0;
    else if (rnd_v > ONE_V)                 res_n = OUT_W'(ONE_V);
    else                                    res_n = rnd_v[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (fin) res_q <= res_n;
    end
  end

  assign res_o  = res_q;
  assign done_o = done_q;

endmodule

// File: rtl/exp_cordic_unit_chk.sv
module exp_cordic_unit_chk
  import exp_cordic_pkg::*;
#(
  parameter int FRAC_W  = 12,
  parameter int ARG_IW  = 4,
  parameter int GUARD_W = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start_i,
  input logic [ARG_IW+FRAC_W-1:0] arg_i,
  input logic                     busy_o,
  input logic                     done_o,
  input logic [FRAC_W:0]          res_o
);

  localparam int ARG_W = ARG_IW + FRAC_W;
  localparam int OUT_W = FRAC_W + 1;
  localparam int IF    = FRAC_W + GUARD_W;
  localparam int AEW   = ARG_W + GUARD_W;
  localparam int LAT   = int'(n_steps(FRAC_W + 2)) + 1;
  localparam logic [AEW-1:0] SAT_TH = AEW'(64'(OUT_W) * ln2_fx(IF));
  localparam logic [FRAC_W:0] ONE   = (FRAC_W+1)'(1) << FRAC_W;

  logic [7:0]       bcnt;
  logic [ARG_W-1:0] cap;
  logic [AEW-1:0]   cap_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      cap  <= '0;
    end else begin
      bcnt <= busy_o ? bcnt + 8'd1 : 8'd0;
      if (start_i && !busy_o) cap <= arg_i;
    end
  end

  assign cap_ext = {cap, {GUARD_W{1'b0}}};

  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (bcnt == 8'(LAT)));

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r2_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  a_r6_upper: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (res_o <= ONE));

  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (cap_ext >= SAT_TH)) |-> (res_o == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(res_o));

endmodule

bind exp_cordic_unit exp_cordic_unit_chk #(
  .FRAC_W(FRAC_W), .ARG_IW(ARG_IW), .GUARD_W(GUARD_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .arg_i(arg_i),
  .busy_o(busy_o), .done_o(done_o), .res_o(res_o)
);

// File: tb/test_exp_cordic_unit.sv
module test_exp_cordic_unit;

  localparam int CLK_PERIOD = 10;
  localparam int FRAC_W     = 12;
  localparam int ARG_IW     = 4;
  localparam int LAT        = 17;
  localparam int ONE        = 4096;
  localparam real LN2       = 0.6931471805599453;

  typedef struct {
    int    arg;
    int    expv;
    int    tol;
    int    t0;
    string tag;
  } exp_item_t;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [15:0] arg_i;
  logic        busy_o;
  logic        done_o;
  logic [12:0] res_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int last_res = 0;
  bit finished = 1'b0;
  exp_item_t sb[$];

  exp_cordic_unit #(.FRAC_W(FRAC_W), .ARG_IW(ARG_IW)) i_exp_cordic_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .arg_i(arg_i),
    .busy_o(busy_o), .done_o(done_o), .res_o(res_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic exp_item_t make_item(input int arg, input string tag);
    exp_item_t it;
    real a;
    a = real'(arg) / 4096.0;
    it.arg = arg;
    it.tag = tag;
    if (a >= 13.0 * LN2) begin
      it.expv = 0;            // R7 saturation
      it.tol  = 0;
    end else begin
      it.expv = int'($floor($exp(-a) * 4096.0 + 0.5));
      it.tol  = (arg == 0) ? 1 : 2;
    end
    it.t0 = 0;
    return it;
  endfunction

  // driver: waits for idle, issues one start, pushes the expected item
  task automatic send(input int arg, input string tag);
    exp_item_t it;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    it      = make_item(arg, tag);
    it.t0   = cyc;
    start_i = 1'b1;
    arg_i   = 16'(arg);
    sb.push_back(it);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R2", "busy after accept", int'(busy_o), 1);
  endtask

  // monitor: pops and compares at every done strobe
  initial begin
    exp_item_t it;
    int diff;
    forever begin
      @(negedge clk);
      if (rst_n && done_o) begin
        if (sb.size() == 0) begin
          check(1'b0, "R3", "unexpected done pulse", 1, 0);
        end else begin
          it   = sb.pop_front();
          diff = int'(res_o) - it.expv;
          if (diff < 0) diff = -diff;
          check(diff <= it.tol, it.tag, $sformatf("result for arg %0d", it.arg), int'(res_o), it.expv);
          check(cyc - it.t0 == LAT + 1, it.tag, "latency in cycles", cyc - it.t0 - 1, LAT);
          check(busy_o == 1'b0, "R2", "busy low with done", int'(busy_o), 0);
          check(int'(res_o) <= ONE, "R6", "upper bound", int'(res_o), ONE);
          last_res = int'(res_o);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: pending results actual %0d expected %0d", sb.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    arg_i   = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy_o == 1'b0, "R1", "busy in reset", int'(busy_o), 0);
    check(done_o == 1'b0, "R1", "done in reset", int'(done_o), 0);
    check(res_o == '0,    "R1", "result in reset", int'(res_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b0 && done_o == 1'b0 && res_o == '0, "R1", "state after reset",
          int'(busy_o) + int'(done_o) + int'(res_o), 0);

    // R6: zero argument
    send(0, "R6");
    // R4: direct range below ln2
    send(1, "R4");
    send(1024, "R4");
    send(1500, "R4");
    send(2048, "R4");
    send(2839, "R4");
    // R5: extended range
    send(2840, "R5");
    send(4096, "R5");
    send(4915, "R5");
    send(10240, "R5");
    send(16384, "R5");
    send(28672, "R5");
    send(34816, "R5");
    send(36000, "R5");
    // R7: shift count at or above output width
    send(37000, "R7");
    send(38912, "R7");
    send(65535, "R7");

    // R3: start pulse while busy is ignored
    send(3000, "R3");
    repeat (4) @(negedge clk);
    start_i = 1'b1;
    arg_i   = 16'd100;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R3", "busy kept after ignored start", int'(busy_o), 1);

    // R9: back-to-back starts in the done cycle
    send(512, "R9");
    send(20000, "R9");
    send(6000, "R9");

    while (sb.size() != 0) @(negedge clk);
    // R8: result held between done pulses
    repeat (12) @(negedge clk);
    check(int'(res_o) == last_res, "R8", "result held", int'(res_o), last_res);
    check(done_o == 1'b0 && busy_o == 1'b0, "R3", "no extra evaluation", int'(done_o) + int'(busy_o), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule